// File: doc/BRIEF.md
# Flow-Through Burst SRAM Control Core

This block holds the clocked control of a synchronous burst static memory whose read path has no output register. On each rising clock edge it samples two address strobes, a burst-advance input, three chip-enable inputs, a global write enable, a byte-write qualifier and four per-lane write enables. It keeps an internal word address made of a fixed upper part and a 2-bit burst count. It writes the selected byte lanes of a small internal array and shows the word at the current address on the data output in the same cycle.

One address strobe, meant for a processor, only loads an address. The other strobe, meant for a memory controller, loads an address and can write on the same edge, and it may restart a burst that is already running. Between strobes, the advance input either steps the burst count or holds it. The global write enable overrides the byte enables. The output-enable flag is raised only for read cycles with the output-enable pin asserted.

Top module: `burst_sram_core`

## Requirements
- R1: A selected edge with `adspN` low loads `addrIn` as the current address and writes nothing, whatever the write enables are. `adspN` takes priority when both strobes are low.
- R2: A selected edge with `adspN` high and `adscN` low loads `addrIn`, even in the middle of a burst, and applies that edge's byte writes to `addrIn`.
- R3: On an edge with both strobes high after a load, `advN` high keeps the current address, and any write on that edge goes to the held address.
- R4: On an edge with both strobes high after a load, `advN` low first steps the address, and any write on that edge goes to the stepped address.
- R5: Stepping increments only the two lowest address bits, wrapping from 3 to 0. The upper address bits do not change during a burst.
- R6: A full 32-bit write occurs when `gwN` is low, whatever `bweN` and `bwN` are. It also occurs when `gwN` is high, `bweN` is low and `bwN` is 4'b0000.
- R7: With `gwN` high and `bweN` low, only lanes whose `bwN` bit is low are written (bit i covers `dataIn[8i+7:8i]`). With `gwN` and `bweN` both high, the edge is a read and leaves the array unchanged.
- R8: The core is selected only when `ce1N` is low, `ce2N` is low and `ce2` is high. A strobe edge while deselected changes neither the address nor the array.
- R9: `dataOutEn` is high only when a load has happened since reset, `oeN` is low, and the current inputs request no write.
- R10: A synchronous reset clears the address to zero and returns the core to idle. Until the next strobe load, `dataOutEn` stays low and edges with no strobe write nothing.
- R11: `dataOut` shows the word at the current address in the cycle that follows the edge that set that address, with no extra register stage. A write to the current address shows up at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| addrIn | input | ADDR_W | Start address captured by a strobe |
| adspN | input | 1 | Processor address strobe, active low, load only |
| adscN | input | 1 | Controller address strobe, active low, load with write |
| advN | input | 1 | Burst advance, active low; high suspends the burst |
| ce1N | input | 1 | Primary chip enable, active low |
| ce2N | input | 1 | Secondary chip enable, active low |
| ce2 | input | 1 | Secondary chip enable, active high |
| gwN | input | 1 | Global write, active low, writes all lanes |
| bweN | input | 1 | Byte-write qualifier, active low |
| bwN | input | 4 | Per-lane write enables, active low |
| oeN | input | 1 | Output enable, active low |
| dataIn | input | 32 | Write data |
| dataOut | output | 32 | Flow-through read data at the current address |
| dataOutEn | output | 1 | Output drive enable for the data bus |

## Verification
The hardest case to reach is a suspended burst that takes a write to an address that is neither freshly loaded nor stepped. From the ports it looks the same as a correct write to the wrong word. The stimulus writes one value with the controller strobe, then writes a second value with the advance input high, then a third with advance low. A later processor-strobe reload replays the words, so a held-address write and a stepped-address write give different read-back values. A similar sequence checks the modulo-4 wrap: five advancing writes starting at an aligned address must overwrite the first word and must not touch the next aligned group.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
  localparam int LANE_N  = 4;
  localparam int LANE_W  = 8;
  localparam int DATA_W  = LANE_N * LANE_W;
  localparam int BURST_W = 2;

  typedef struct packed {
    logic              loadAddr;
    logic              stepAddr;
    logic [LANE_N-1:0] laneWr;
  } strobeT;
endpackage

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
  import burst_sram_pkg::*;
(
  input  logic              adspN,
  input  logic              adscN,
  input  logic              advN,
  input  logic              ce1N,
  input  logic              ce2N,
  input  logic              ce2,
  input  logic              gwN,
  input  logic              bweN,
  input  logic [LANE_N-1:0] bwN,
  input  logic              oeN,
  input  logic              active,
  output strobeT            strb,
  output logic              dataOutEn
);
  logic chipSel;
  logic procLoad;
  logic ctrlLoad;
  logic contCycle;
  logic [LANE_N-1:0] laneReq;

  always_comb begin
    chipSel   = !ce1N && !ce2N && ce2;
    procLoad  = chipSel && !adspN;
    ctrlLoad  = chipSel && adspN && !adscN;
    contCycle = adspN && adscN && active;
    if (!gwN)       laneReq = '1;
    else if (!bweN) laneReq = ~bwN;
    else            laneReq = '0;

    strb.loadAddr = procLoad || ctrlLoad;
    strb.stepAddr = contCycle && !advN;
    strb.laneWr   = (ctrlLoad || contCycle) ? laneReq : '0;
    dataOutEn     = active && !oeN && (laneReq == '0);
  end
endmodule

// File: rtl/burst_sram_datapath.sv
module burst_sram_datapath
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  strobeT            strb,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic              active,
  output logic [DATA_W-1:0] dataOut
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [ADDR_W-1:0]  curAddr;
  logic [ADDR_W-1:0]  nextAddr;
  logic [BURST_W-1:0] beatNext;
  logic [DATA_W-1:0]  mem [DEPTH];

  always_comb begin
    beatNext = curAddr[BURST_W-1:0] + BURST_W'(1);
    if (strb.loadAddr)      nextAddr = addrIn;
    else if (strb.stepAddr) nextAddr = {curAddr[ADDR_W-1:BURST_W], beatNext};
    else                    nextAddr = curAddr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      curAddr <= '0;
      active  <= 1'b0;
    end else begin
      curAddr <= nextAddr;
      if (strb.loadAddr) active <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    for (int lane = 0; lane < LANE_N; lane++) begin
      if (!rst && strb.laneWr[lane])
        mem[nextAddr][lane*LANE_W +: LANE_W] <= dataIn[lane*LANE_W +: LANE_W];
    end
  end

  assign dataOut = mem[curAddr];
endmodule

// File: rtl/burst_sram_core.sv
module burst_sram_core
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              adspN,
  input  logic              adscN,
  input  logic              advN,
  input  logic              ce1N,
  input  logic              ce2N,
  input  logic              ce2,
  input  logic              gwN,
  input  logic              bweN,
  input  logic [3:0]        bwN,
  input  logic              oeN,
  input  logic [31:0]       dataIn,
  output logic [31:0]       dataOut,
  output logic              dataOutEn
);
  strobeT strb;
  logic   active;

  burst_sram_ctrl u_ctrl (
    .adspN(adspN), .adscN(adscN), .advN(advN),
    .ce1N(ce1N), .ce2N(ce2N), .ce2(ce2),
    .gwN(gwN), .bweN(bweN), .bwN(bwN), .oeN(oeN),
    .active(active), .strb(strb), .dataOutEn(dataOutEn)
  );

  burst_sram_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .addrIn(addrIn),
    .dataIn(dataIn), .active(active), .dataOut(dataOut)
  );
endmodule

// File: rtl/burst_sram_core_chk.sv
module burst_sram_core_chk (
  input logic        clk,
  input logic        rst,
  input logic        adspN,
  input logic        adscN,
  input logic        advN,
  input logic        ce1N,
  input logic        ce2N,
  input logic        ce2,
  input logic        gwN,
  input logic        bweN,
  input logic [3:0]  bwN,
  input logic        oeN,
  input logic [31:0] dataOut,
  input logic        dataOutEn,
  input logic [3:0]  laneWr
);
  logic selNow;
  logic noWrite;
  assign selNow  = !ce1N && !ce2N && ce2;
  assign noWrite = gwN && (bweN || (&bwN));

  AST_PROC_STROBE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    !adspN |-> (laneWr == 4'b0000)); // R1
  AST_HOLD_KEEPS_DATA: assert property (@(posedge clk) disable iff (rst)
    (adspN && adscN && advN && noWrite) |=> $stable(dataOut)); // R3
  AST_GLOBAL_WRITE_FULL: assert property (@(posedge clk) disable iff (rst)
    (selNow && adspN && !adscN && !gwN) |-> (laneWr == 4'b1111)); // R6
  AST_DESELECT_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (!selNow && (!adspN || !adscN)) |=> $stable(dataOut)); // R8
  AST_OUT_EN_READ_ONLY: assert property (@(posedge clk) disable iff (rst)
    dataOutEn |-> (!oeN && noWrite)); // R9
  AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !dataOutEn); // R10
endmodule

bind burst_sram_core burst_sram_core_chk u_chk (
  .clk(clk), .rst(rst), .adspN(adspN), .adscN(adscN), .advN(advN),
  .ce1N(ce1N), .ce2N(ce2N), .ce2(ce2), .gwN(gwN), .bweN(bweN),
  .bwN(bwN), .oeN(oeN), .dataOut(dataOut), .dataOutEn(dataOutEn),
  .laneWr(strb.laneWr)
);

// File: tb/burst_sram_core_bench.sv
`timescale 1ns/1ps
module burst_sram_core_bench;
  // op: 0 = no strobe, 1 = processor strobe, 2 = controller strobe
  typedef struct packed {
    logic [1:0]  op;
    logic        sel;
    logic        adv;
    logic        gw;
    logic        bwe;
    logic [3:0]  bw;
    logic        oe;
    logic [5:0]  addr;
    logic [31:0] din;
    logic        chkD;
    logic [31:0] expD;
    logic        expEn;
    logic [3:0]  req;
  } vecT;

  localparam int NV = 24;
  localparam vecT VEC [NV] = '{
    '{2'd2,1'b1,1'b1,1'b0,1'b1,4'hF,1'b1,6'h08,32'hA0A0A0A0,1'b1,32'hA0A0A0A0,1'b0,4'd2},  // R2 controller write
    '{2'd0,1'b1,1'b0,1'b0,1'b1,4'hF,1'b1,6'h00,32'hA1A1A1A1,1'b1,32'hA1A1A1A1,1'b0,4'd4},  // R4 to 0x09
    '{2'd0,1'b1,1'b0,1'b1,1'b0,4'h0,1'b1,6'h00,32'hA2A2A2A2,1'b1,32'hA2A2A2A2,1'b0,4'd6},  // R6 all bytes
    '{2'd0,1'b1,1'b0,1'b0,1'b1,4'hF,1'b1,6'h00,32'hA3A3A3A3,1'b1,32'hA3A3A3A3,1'b0,4'd5},  // R5 to 0x0B
    '{2'd0,1'b1,1'b0,1'b0,1'b1,4'hF,1'b1,6'h00,32'hA4A4A4A4,1'b1,32'hA4A4A4A4,1'b0,4'd5},  // R5 wrap to 0x08
    '{2'd1,1'b1,1'b1,1'b0,1'b1,4'hF,1'b0,6'h08,32'hFFFFFFFF,1'b1,32'hA4A4A4A4,1'b0,4'd1},  // R1 no write
    '{2'd0,1'b1,1'b1,1'b1,1'b1,4'hF,1'b0,6'h00,32'h0,1'b1,32'hA4A4A4A4,1'b1,4'd11},        // R11 read
    '{2'd0,1'b1,1'b0,1'b1,1'b1,4'hF,1'b0,6'h00,32'h0,1'b1,32'hA1A1A1A1,1'b1,4'd4},         // R4
    '{2'd0,1'b1,1'b0,1'b1,1'b1,4'hF,1'b0,6'h00,32'h0,1'b1,32'hA2A2A2A2,1'b1,4'd5},         // R5
    '{2'd0,1'b1,1'b0,1'b1,1'b1,4'hF,1'b0,6'h00,32'h0,1'b1,32'hA3A3A3A3,1'b1,4'd5},         // R5
    '{2'd0,1'b1,1'b0,1'b1,1'b1,4'hF,1'b0,6'h00,32'h0,1'b1,32'hA4A4A4A4,1'b1,4'd5},         // R5 wrap
    '{2'd0,1'b1,1'b1,1'b1,1'b0,4'hA,1'b1,6'h00,32'h11223344,1'b1,32'hA422A444,1'b0,4'd7},  // R7 lanes 0,2
    '{2'd0,1'b1,1'b1,1'b1,1'b1,4'h0,1'b0,6'h00,32'h55555555,1'b1,32'hA422A444,1'b1,4'd7},  // R7 read
    '{2'd2,1'b0,1'b1,1'b0,1'b1,4'hF,1'b0,6'h20,32'h66666666,1'b1,32'hA422A444,1'b0,4'd8},  // R8 deselected
    '{2'd0,1'b1,1'b1,1'b1,1'b1,4'hF,1'b0,6'h00,32'h0,1'b1,32'hA422A444,1'b1,4'd8},         // R8
    '{2'd1,1'b1,1'b1,1'b1,1'b1,4'hF,1'b0,6'h30,32'h0,1'b0,32'h0,1'b1,4'd9},                // R9
    '{2'd0,1'b1,1'b0,1'b1,1'b1,4'hF,1'b1,6'h00,32'h0,1'b0,32'h0,1'b0,4'd9},                // R9 oe high
    '{2'd2,1'b1,1'b1,1'b1,1'b1,4'hF,1'b0,6'h08,32'h0,1'b1,32'hA422A444,1'b1,4'd2},         // R2 mid-burst
    '{2'd2,1'b1,1'b1,1'b0,1'b1,4'hF,1'b1,6'h14,32'hB0B0B0B0,1'b1,32'hB0B0B0B0,1'b0,4'd2},  // R2
    '{2'd0,1'b1,1'b1,1'b0,1'b1,4'hF,1'b1,6'h00,32'hB1B1B1B1,1'b1,32'hB1B1B1B1,1'b0,4'd3},  // R3 held
    '{2'd0,1'b1,1'b0,1'b0,1'b1,4'hF,1'b1,6'h00,32'hB2B2B2B2,1'b1,32'hB2B2B2B2,1'b0,4'd4},  // R4 stepped
    '{2'd1,1'b1,1'b1,1'b1,1'b1,4'hF,1'b0,6'h14,32'h0,1'b1,32'hB1B1B1B1,1'b1,4'd3},         // R3
    '{2'd0,1'b1,1'b0,1'b1,1'b1,4'hF,1'b0,6'h00,32'h0,1'b1,32'hB2B2B2B2,1'b1,4'd4},         // R4
    '{2'd2,1'b1,1'b1,1'b0,1'b1,4'hF,1'b1,6'h00,32'hD0D0D0D0,1'b1,32'hD0D0D0D0,1'b0,4'd6}   // R6 gw over bwe
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [5:0] addrIn = '0;
  logic adspN = 1'b1, adscN = 1'b1, advN = 1'b1;
  logic ce1N = 1'b0, ce2N = 1'b0, ce2 = 1'b1;
  logic gwN = 1'b1, bweN = 1'b1, oeN = 1'b1;
  logic [3:0] bwN = 4'hF;
  logic [31:0] dataIn = '0;
  logic [31:0] dataOut;
  logic dataOutEn;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  burst_sram_core u_burst_sram_core (
    .clk(clk), .rst(rst), .addrIn(addrIn), .adspN(adspN), .adscN(adscN),
    .advN(advN), .ce1N(ce1N), .ce2N(ce2N), .ce2(ce2), .gwN(gwN),
    .bweN(bweN), .bwN(bwN), .oeN(oeN), .dataIn(dataIn),
    .dataOut(dataOut), .dataOutEn(dataOutEn)
  );

  task automatic applyVec(input vecT v);
    @(negedge clk);
    adspN  = !(v.op == 2'd1);
    adscN  = !(v.op == 2'd2);
    ce1N   = !v.sel;
    ce2N   = !v.sel;
    ce2    = v.sel;
    advN   = v.adv;
    gwN    = v.gw;
    bweN   = v.bwe;
    bwN    = v.bw;
    oeN    = v.oe;
    addrIn = v.addr;
    dataIn = v.din;
    @(posedge clk);
    #1;
  endtask

  task automatic checkVal(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    vecT rd;
    rd = '{2'd0,1'b1,1'b1,1'b1,1'b1,4'hF,1'b0,6'h00,32'h0,1'b0,32'h0,1'b0,4'd10};
    repeat (3) @(posedge clk);
    #1;
    checkVal("R10 enable in reset", {31'b0, dataOutEn}, 32'd0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      applyVec(VEC[i]);
      if (VEC[i].chkD)
        checkVal($sformatf("R%0d row %0d data", VEC[i].req, i), dataOut, VEC[i].expD);
      checkVal($sformatf("R%0d row %0d enable", VEC[i].req, i), {31'b0, dataOutEn}, {31'b0, VEC[i].expEn});
    end

    // R10: reset returns to idle; cycles without a strobe neither write nor enable
    @(negedge clk);
    rst = 1'b1;
    applyVec(rd);
    @(negedge clk);
    rst = 1'b0;
    rd.adv = 1'b0; rd.gw = 1'b0; rd.oe = 1'b1; rd.din = 32'hC0C0C0C0;
    applyVec(rd);
    checkVal("R10 idle write ignored enable", {31'b0, dataOutEn}, 32'd0);
    rd.adv = 1'b1; rd.gw = 1'b1; rd.oe = 1'b0;
    applyVec(rd);
    checkVal("R10 idle read enable", {31'b0, dataOutEn}, 32'd0);
    checkVal("R10 idle address zero data", dataOut, 32'hD0D0D0D0);
    rd.op = 2'd1; rd.addr = 6'h00;
    applyVec(rd);
    checkVal("R10 reload data", dataOut, 32'hD0D0D0D0);
    checkVal("R10 reload enable", {31'b0, dataOutEn}, 32'd1);
    // R5: upper bits fixed, group 0x08..0x0B untouched by burst at 0x14
    rd.addr = 6'h08;
    applyVec(rd);
    checkVal("R5 group intact", dataOut, 32'hA422A444);
    rd.op = 2'd0; rd.adv = 1'b0;
    applyVec(rd);
    checkVal("R5 next in group", dataOut, 32'hA1A1A1A1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule